// File: doc/BRIEF.md
# Lowest-Index Channel Power-On Sequencer

This block sits between the activation requests for a group of line drivers and the drivers themselves. When several channels ask to switch on, it powers them up one at a time, so that the inrush current of one channel's load has died away before the next channel starts drawing current. A channel is in its power-on phase from the moment it is granted until its current-limit flag first drops. During that phase no other channel is granted. Pending channels are served lowest index first, whatever order their requests arrived in.

New requests are not accepted while the thermal gate is raised. Requests that were already queued are still served. A refused request is picked up once the gate falls, as long as its request bit is still high. Switching a channel off never waits in the queue. A strap input bypasses the whole mechanism so that every request is granted on the next clock. The block runs on a slow sequencer clock of nominally 8 kHz and uses a synchronous active-high reset.

Top module: `poweron_sequencer`

## Requirements
- R1: While reset is high, at the next clock edge every drive enable and every power-on flag is 0, and every queued request is discarded.
- R2: At most one power-on flag is high at any time. A channel's drive enable and its power-on flag rise at the same clock edge. A request seen at an edge with the block idle gives a grant at the following edge (two edges in total).
- R3: After a power-on flag falls, the next queued channel is granted one clock edge later, never at the same edge.
- R4: When several channels are queued, the lowest channel index is granted first. Requests arriving for channels 1, 3 and 0 while channel 2 powers up are served in the order 0, 1, 3.
- R5: A power-on flag falls at the first edge that samples that channel's current-limit flag low. While the flag stays high, the sequence stalls.
- R6: A current-limit flag on a channel whose power-on phase has ended neither raises a power-on flag nor delays any grant.
- R7: While the thermal gate is high, a request that is not yet queued is refused and queued requests are still served. A refused request is queued at the first edge that samples the gate low with the request still high.
- R8: A queued request whose request bit falls before it is granted is dropped and is never granted.
- R9: A request bit sampled low clears that channel's drive enable and power-on flag at that edge, in every phase.
- R10: With the bypass strap high, the drive enable of every channel equals its request bit at the next edge, all power-on flags stay 0, and the thermal gate is ignored. Channels that are already on stay on when the strap is lowered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| act_req | input | NUM_CH | Per-channel activation request level (1 = on) |
| ilim_flag | input | NUM_CH | Per-channel current-limit condition |
| hot_gate | input | 1 | Thermal gate, high between the upper and lower thresholds of its hysteresis |
| seq_bypass | input | 1 | Strap: 1 grants requests directly, with no sequencing |
| drv_en | output | NUM_CH | Per-channel drive enable (registered) |
| pon_flag | output | NUM_CH | Per-channel power-on phase flag (registered) |

## Verification
The bench builds the block with its default of four channels. At that size every one of the 16 request masks can be swept, raised at once from idle, and the grant order and the stall and release timing of each mask can be derived arithmetically from its set bits. The same 16 masks are swept again with the bypass strap high. Directed sequences cover the 1-3-0 ordering example, the thermal refusal and later pickup, withdrawal of a queued request, switch-off of channels that are ramping and channels that are on, and a current-limit flag on a channel that is already on.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  // Per-channel life cycle.
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,  // off, nothing stored
    CH_QUEUED = 2'd1,  // request stored, waiting for its turn
    CH_RAMP   = 2'd2,  // granted, still in start-up current limit
    CH_LIVE   = 2'd3   // granted, power-on phase over
  } ch_phase_e;

  function automatic logic phase_drives(ch_phase_e p);
    return (p == CH_RAMP) || (p == CH_LIVE);
  endfunction

endpackage

// File: rtl/pwrseq_pick.sv
// Lowest-index selector: at most one winner, and only while nobody ramps.
module pwrseq_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] queued,
  input  logic              busy,
  output logic [NUM_CH-1:0] win
);

  logic [NUM_CH:0] seen_below;

  assign seen_below[0] = 1'b0;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chain
    assign seen_below[gi+1] = seen_below[gi] | queued[gi];
    assign win[gi]          = ~busy & queued[gi] & ~seen_below[gi];
  end

endmodule

// File: rtl/pwrseq_chan.sv
module pwrseq_chan
  import pwrseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  logic      ilim,
  input  logic      hot,
  input  logic      bypass,
  input  logic      win,
  output ch_phase_e phase,
  output logic      grant_q,
  output logic      pof_q
);

  ch_phase_e nxt;

  always_comb begin
    nxt = phase;
    if (!req) begin
      nxt = CH_IDLE;                     // switch-off skips the queue
    end else if (bypass) begin
      nxt = CH_LIVE;                     // strap: grant at once
    end else begin
      unique case (phase)
        CH_IDLE:   nxt = hot  ? CH_IDLE : CH_QUEUED;
        CH_QUEUED: nxt = win  ? CH_RAMP : CH_QUEUED;
        CH_RAMP:   nxt = ilim ? CH_RAMP : CH_LIVE;
        CH_LIVE:   nxt = CH_LIVE;
        default:   nxt = CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= CH_IDLE;
      grant_q <= 1'b0;
      pof_q   <= 1'b0;
    end else begin
      phase   <= nxt;
      grant_q <= phase_drives(nxt);
      pof_q   <= (nxt == CH_RAMP);
    end
  end

endmodule

// File: rtl/poweron_sequencer.sv
module poweron_sequencer
  import pwrseq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] act_req,
  input  logic [NUM_CH-1:0] ilim_flag,
  input  logic              hot_gate,
  input  logic              seq_bypass,
  output logic [NUM_CH-1:0] drv_en,
  output logic [NUM_CH-1:0] pon_flag
);

  ch_phase_e         phase [NUM_CH];
  logic [NUM_CH-1:0] queued;
  logic [NUM_CH-1:0] win;
  logic              busy;

  // Registered power-on flags tell whether a channel is still ramping.
  assign busy = |pon_flag;

  pwrseq_pick #(.NUM_CH(NUM_CH)) u_pick (
    .queued (queued),
    .busy   (busy),
    .win    (win)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    assign queued[gc] = (phase[gc] == CH_QUEUED);

    pwrseq_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .req     (act_req[gc]),
      .ilim    (ilim_flag[gc]),
      .hot     (hot_gate),
      .bypass  (seq_bypass),
      .win     (win[gc]),
      .phase   (phase[gc]),
      .grant_q (drv_en[gc]),
      .pof_q   (pon_flag[gc])
    );
  end

endmodule

// File: rtl/poweron_sequencer_chk.sv
module poweron_sequencer_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] act_req,
  input logic [NUM_CH-1:0] ilim_flag,
  input logic              hot_gate,
  input logic              seq_bypass,
  input logic [NUM_CH-1:0] drv_en,
  input logic [NUM_CH-1:0] pon_flag
);

  assert_single_ramp_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pon_flag));

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_prop
    assert_flag_needs_drive_R2: assert property (@(posedge clk) disable iff (rst)
      pon_flag[gi] |-> drv_en[gi]);

    assert_gap_after_fall_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(pon_flag[gi]) |-> ($past(pon_flag) == '0));

    assert_stall_in_limit_R5: assert property (@(posedge clk) disable iff (rst)
      (!seq_bypass && act_req[gi] && pon_flag[gi] && ilim_flag[gi]) |=> pon_flag[gi]);

    assert_off_at_once_R9: assert property (@(posedge clk) disable iff (rst)
      !act_req[gi] |=> (!drv_en[gi] && !pon_flag[gi]));

    assert_bypass_grant_R10: assert property (@(posedge clk) disable iff (rst)
      (seq_bypass && act_req[gi]) |=> (drv_en[gi] && !pon_flag[gi]));

    assert_bypass_ignores_heat_R10: assert property (@(posedge clk) disable iff (rst)
      (seq_bypass && hot_gate && act_req[gi]) |=> drv_en[gi]);
  end

endmodule

bind poweron_sequencer poweron_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .act_req    (act_req),
  .ilim_flag  (ilim_flag),
  .hot_gate   (hot_gate),
  .seq_bypass (seq_bypass),
  .drv_en     (drv_en),
  .pon_flag   (pon_flag)
);

// File: tb/sim_poweron_sequencer.sv
`timescale 1ns/1ps
module sim_poweron_sequencer;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] req = '0;
  logic [NCH-1:0] ilim = '1;
  logic           hot = 1'b0;
  logic           byp = 1'b0;
  logic [NCH-1:0] drv;
  logic [NCH-1:0] pof;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  poweron_sequencer #(.NUM_CH(NCH)) u0 (
    .clk        (clk),
    .rst        (rst),
    .act_req    (req),
    .ilim_flag  (ilim),
    .hot_gate   (hot),
    .seq_bypass (byp),
    .drv_en     (drv),
    .pon_flag   (pof)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; ilim = '1; hot = 1'b0; byp = 1'b0;
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    logic [NCH-1:0] on_set;
    logic [NCH-1:0] left;
    int k;

    // R1: reset state
    do_reset();
    chk("R1 reset drv", drv, '0);
    chk("R1 reset pof", pof, '0);

    // R2 R3 R4 R5: sweep all request masks, raised together from idle
    for (int m = 1; m < (1 << NCH); m++) begin
      do_reset();
      req = NCH'(m);
      tick();                                   // requests queued
      on_set = '0;
      left   = NCH'(m);
      while (left != '0) begin
        k = 0;
        while (!left[k]) k++;
        tick();                                 // lowest queued granted
        chk("R4 sweep order pof", pof, NCH'(1) << k);
        chk("R2 sweep drv with pof", drv, on_set | (NCH'(1) << k));
        tick();                                 // limit still high
        chk("R5 sweep stall", pof, NCH'(1) << k);
        ilim[k] = 1'b0;
        tick();                                 // flag falls, no grant yet
        chk("R3 sweep gap pof", pof, '0);
        on_set  = on_set | (NCH'(1) << k);
        left[k] = 1'b0;
        chk("R3 sweep gap drv", drv, on_set);
      end
    end

    // R4: 1,3,0 arriving during channel 2 ramp -> 0,1,3
    do_reset();
    req = 4'b0100; tick(); tick();
    chk("R2 first grant", pof, 4'b0100);
    req[1] = 1'b1; tick();
    req[3] = 1'b1; tick();
    req[0] = 1'b1; tick();
    chk("R5 stalled ch2", pof, 4'b0100);
    ilim[2] = 1'b0; tick();
    chk("R3 ch2 flag down", pof, 4'b0000);
    tick();
    chk("R4 ch0 first", pof, 4'b0001);
    ilim[0] = 1'b0; tick(); tick();
    chk("R4 ch1 second", pof, 4'b0010);
    ilim[1] = 1'b0; tick(); tick();
    chk("R4 ch3 third", pof, 4'b1000);
    chk("R4 all driven", drv, 4'b1111);

    // R6: limit on an already-live channel
    ilim[0] = 1'b1;
    ilim[3] = 1'b0; tick();
    chk("R6 live limit no flag", pof, 4'b0000);
    // R9: switch off a live channel
    req[1] = 1'b0; tick();
    chk("R9 live off", drv, 4'b1101);
    ilim[1] = 1'b1;
    req[1] = 1'b1; tick(); tick();
    chk("R6 live limit no delay", pof, 4'b0010);
    // R9: switch off a ramping channel
    req[1] = 1'b0; tick();
    chk("R9 ramp off drv", drv, 4'b1101);
    chk("R9 ramp off pof", pof, 4'b0000);

    // R7: thermal gate
    do_reset();
    req = 4'b0001; tick(); tick();
    req[2] = 1'b1; tick();                      // queued while cool
    hot = 1'b1;
    req[1] = 1'b1; tick();                      // refused
    ilim[0] = 1'b0; tick(); tick();
    chk("R7 stored served hot", pof, 4'b0100);
    ilim[2] = 1'b0; tick(); tick(); tick();
    chk("R7 new refused drv", drv, 4'b0101);
    chk("R7 new refused pof", pof, 4'b0000);
    hot = 1'b0; tick(); tick();
    chk("R7 picked up cool", pof, 4'b0010);
    chk("R7 picked up drv", drv, 4'b0111);

    // R8: withdrawn queued request
    do_reset();
    req = 4'b0001; tick(); tick();
    req[1] = 1'b1; tick();
    req[1] = 1'b0; tick();
    ilim[0] = 1'b0; tick(); tick(); tick();
    chk("R8 dropped drv", drv, 4'b0001);
    chk("R8 dropped pof", pof, 4'b0000);

    // R1: reset during activity
    do_reset();
    req = 4'b0011; tick(); tick();
    rst = 1'b1; tick();
    chk("R1 mid reset drv", drv, '0);
    chk("R1 mid reset pof", pof, '0);

    // R10: bypass strap sweep, gate high
    do_reset();
    byp = 1'b1; hot = 1'b1;
    for (int m = 0; m < (1 << NCH); m++) begin
      req = NCH'(m); tick();
      chk("R10 bypass drv", drv, NCH'(m));
      chk("R10 bypass pof", pof, '0);
    end
    req = 4'b0110; tick();
    byp = 1'b0; hot = 1'b0; tick(); tick();
    chk("R10 stays on after strap", drv, 4'b0110);
    chk("R10 no flag after strap", pof, 4'b0000);

    report();
  end

endmodule